// File: doc/BRIEF.md
# Two-Stage Serial Register-Read Bridge

This block is a slave on a two-wire serial bus (clock and open-drain data) that serves register reads from two address spaces. Registers held next to the block are read in a single transaction: the host writes a device address and a register index, issues a repeated START, reads one byte and stops. The block returns the byte from the local register file at once.

Sensor registers sit behind a slow link, and reading one takes two transactions. The first read of a sensor register is acknowledged and returns a placeholder byte, and it sends a one-cycle fetch request with the register index toward the sensor side. That side answers after a latency that varies. While the fetch is outstanding, a read of the same index is refused: its read address byte gets no acknowledge. After the answer has arrived, the next read of that index is acknowledged and returns the fetched byte. That read also uses up the stored result. If a read names a different sensor index, it replaces the pending fetch. The old result is then thrown away.

Both bus lines pass through a synchronizer stage. START and STOP are found as data-line edges while the clock line is high. The block never stretches the clock.

Top module: `sreg_bridge_slave`

## Requirements
- R1: After reset, `sda_oe` is 0 and `fetch_req` is 0.
- R2: Only 7-bit device addresses 0x20 (local space) and 0x11 (sensor space) are acknowledged in the write phase; any other address leaves SDA released in the acknowledge slot.
- R3: The register-index byte is acknowledged only if its bit 7 matches the space of the device address: 1 under 0x20, 0 under 0x11; otherwise it is not acknowledged.
- R4: A read with address 0x20 is acknowledged and returns, within the same transaction, `lreg_data` for `lreg_addr` equal to index bits 6..0.
- R5: A sensor read with no stored result and no pending fetch for its index is acknowledged, returns 0xFF, and produces exactly one `fetch_req` pulse with `fetch_addr` equal to index bits 6..0.
- R6: While a fetch for index X is outstanding, a read of X has its read address byte not acknowledged, and no byte is driven.
- R7: Once `fetch_vld` has delivered the result for X, the next read of X is acknowledged and returns `fetch_data`. The read after that is a first read again: it returns 0xFF and starts a new fetch.
- R8: A sensor read of an index Y other than the pending or stored index X is acknowledged and returns 0xFF. The result for X is discarded, and a fetch for Y is issued. If X is still outstanding, that fetch goes out after X's answer, which is dropped. The next read of Y after that returns Y's data.
- R9: The read-phase device address must name the same space as the write phase of the same transaction. A read with no acknowledged register index since the last STOP is not acknowledged.
- R10: `sda_oe` changes only while SCL is low, and it is 0 after every STOP.
- R11: At most one fetch is outstanding at a time, and `fetch_req` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen on the pin |
| sda_i | input | 1 | Serial data line as seen on the pin |
| sda_oe | output | 1 | 1 pulls the data line low (open drain) |
| lreg_addr | output | 7 | Index into the local register file |
| lreg_data | input | 8 | Local register file read data |
| fetch_req | output | 1 | One-cycle request to fetch a sensor register |
| fetch_addr | output | 7 | Sensor register index for the request |
| fetch_vld | input | 1 | One-cycle pulse: fetched data valid |
| fetch_data | input | 8 | Fetched sensor register value |

## Verification
A change on a bus pin reaches the protocol logic two cycles later, through the synchronizer. The block then drives acknowledge and data bits on the third clock edge after the SCL pin falls. The bench drives each quarter bit for eight cycles and samples SDA eight cycles after it raises SCL, so every slave bit has settled well before it is sampled. Fetch results can be used from the cycle after `fetch_vld`, and the bench waits on its count of answered fetches before it starts the read that expects them. Fetch requests are counted by the sensor model rather than timed.

// File: rtl/sbr_pkg.sv
package sbr_pkg;
   localparam int BYTE_W = 8;
   localparam int IDX_W  = BYTE_W - 1;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DEV,
      ST_DEV_ACK,
      ST_SUB,
      ST_SUB_ACK,
      ST_TX,
      ST_MACK,
      ST_WAIT
   } sbr_state_e;
endpackage

// File: rtl/sbr_sync.sv
module sbr_sync #(
   parameter int W       = 2,
   parameter int STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   localparam int CHAIN_W = W * STAGES;

   if (STAGES < 2) begin : g_bad_stages
      $error("sbr_sync: STAGES must be at least 2");
   end

   logic [CHAIN_W-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[CHAIN_W-W-1:0], d};
   end

   assign q = chain[CHAIN_W-1 -: W];
endmodule

// File: rtl/sbr_cond_det.sv
module sbr_cond_det (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic start_det,
   output logic stop_det,
   output logic scl_rise,
   output logic scl_fall
);
   logic scl_p, sda_p;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_p <= 1'b1;
         sda_p <= 1'b1;
      end else begin
         scl_p <= scl_s;
         sda_p <= sda_s;
      end
   end

   assign start_det = scl_s & scl_p & sda_p & ~sda_s;
   assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
   assign scl_rise  = scl_s & ~scl_p;
   assign scl_fall  = ~scl_s & scl_p;
endmodule

// File: rtl/sbr_fetch_ctl.sv
module sbr_fetch_ctl #(
   parameter int IDX_W  = 7,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [IDX_W-1:0]  start_idx_i,
   input  logic              consume_i,
   output logic              busy_o,
   output logic              ready_o,
   output logic [IDX_W-1:0]  tag_o,
   output logic [DATA_W-1:0] data_o,
   output logic              req_o,
   input  logic              vld_i,
   input  logic [DATA_W-1:0] vld_data_i
);
   logic redo;
   logic retarget;

   assign retarget = start_i && (start_idx_i != tag_o);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_o  <= 1'b0;
         ready_o <= 1'b0;
         redo    <= 1'b0;
         tag_o   <= '0;
         data_o  <= '0;
         req_o   <= 1'b0;
      end else begin
         req_o <= 1'b0;
         if (vld_i && busy_o) begin
            if (redo || retarget) begin
               req_o <= 1'b1;
               redo  <= 1'b0;
               if (start_i) tag_o <= start_idx_i;
            end else begin
               busy_o  <= 1'b0;
               ready_o <= 1'b1;
               data_o  <= vld_data_i;
            end
         end else if (start_i) begin
            tag_o <= start_idx_i;
            if (busy_o) begin
               redo <= redo | retarget;
            end else begin
               busy_o  <= 1'b1;
               ready_o <= 1'b0;
               req_o   <= 1'b1;
            end
         end else if (consume_i) begin
            ready_o <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/sreg_bridge_slave.sv
module sreg_bridge_slave
   import sbr_pkg::*;
#(
   parameter int             SYNC_STAGES  = 2,
   parameter logic [IDX_W-1:0] LOC_DEV    = 7'h20,
   parameter logic [IDX_W-1:0] SEN_DEV    = 7'h11,
   parameter logic [BYTE_W-1:0] INVALID_BYTE = 8'hFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe,
   output logic [IDX_W-1:0]  lreg_addr,
   input  logic [BYTE_W-1:0] lreg_data,
   output logic              fetch_req,
   output logic [IDX_W-1:0]  fetch_addr,
   input  logic              fetch_vld,
   input  logic [BYTE_W-1:0] fetch_data
);
   localparam logic [2:0] LAST_BIT = 3'(BYTE_W - 1);

   if (LOC_DEV == SEN_DEV) begin : g_bad_dev
      $error("sreg_bridge_slave: the two device addresses must differ");
   end

   logic [1:0] pins_s;
   logic       scl_s, sda_s;
   logic       start_det, stop_det, scl_rise, scl_fall;

   sbr_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q(pins_s)
   );
   assign scl_s = pins_s[1];
   assign sda_s = pins_s[0];

   sbr_cond_det u_det (
      .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
      .start_det(start_det), .stop_det(stop_det),
      .scl_rise(scl_rise), .scl_fall(scl_fall)
   );

   sbr_state_e         st;
   logic [2:0]         cnt;
   logic [IDX_W-1:0]   shreg;
   logic [BYTE_W-1:0]  txsh;
   logic [IDX_W-1:0]   idx_q;
   logic               idx_ok, space_loc, ack_r, rd_r, in_ack;

   logic               f_busy, f_ready;
   logic [IDX_W-1:0]   f_tag;
   logic [BYTE_W-1:0]  f_data;

   logic [BYTE_W-1:0]  rx_byte;
   logic               is_loc, is_sen, dev_done, sub_done;
   logic               sen_hit, sen_wait, rd_ok, f_start, f_consume;

   assign rx_byte  = {shreg, sda_s};
   assign is_loc   = rx_byte[BYTE_W-1:1] == LOC_DEV;
   assign is_sen   = rx_byte[BYTE_W-1:1] == SEN_DEV;
   assign dev_done = scl_rise && (st == ST_DEV) && (cnt == LAST_BIT);
   assign sub_done = scl_rise && (st == ST_SUB) && (cnt == LAST_BIT);
   assign sen_hit  = f_ready && (f_tag == idx_q);
   assign sen_wait = f_busy && (f_tag == idx_q);
   assign rd_ok    = idx_ok && ((is_loc && space_loc) || (is_sen && !space_loc))
                     && !(!space_loc && sen_wait);
   assign f_start   = dev_done && rx_byte[0] && rd_ok && !space_loc && !sen_hit;
   assign f_consume = dev_done && rx_byte[0] && rd_ok && !space_loc && sen_hit;

   sbr_fetch_ctl #(.IDX_W(IDX_W), .DATA_W(BYTE_W)) u_fetch (
      .clk(clk), .rst_n(rst_n),
      .start_i(f_start), .start_idx_i(idx_q), .consume_i(f_consume),
      .busy_o(f_busy), .ready_o(f_ready), .tag_o(f_tag), .data_o(f_data),
      .req_o(fetch_req), .vld_i(fetch_vld), .vld_data_i(fetch_data)
   );

   assign fetch_addr = f_tag;
   assign lreg_addr  = idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         cnt       <= '0;
         shreg     <= '0;
         txsh      <= '0;
         idx_q     <= '0;
         idx_ok    <= 1'b0;
         space_loc <= 1'b0;
         ack_r     <= 1'b0;
         rd_r      <= 1'b0;
         in_ack    <= 1'b0;
         sda_oe    <= 1'b0;
      end else if (start_det) begin
         st     <= ST_DEV;
         cnt    <= '0;
         in_ack <= 1'b0;
         sda_oe <= 1'b0;
      end else if (stop_det) begin
         st     <= ST_IDLE;
         idx_ok <= 1'b0;
         sda_oe <= 1'b0;
      end else begin
         unique case (st)
            ST_DEV: if (scl_rise) begin
               shreg <= rx_byte[IDX_W-1:0];
               cnt   <= cnt + 3'd1;
               if (dev_done) begin
                  rd_r   <= rx_byte[0];
                  in_ack <= 1'b0;
                  st     <= ST_DEV_ACK;
                  if (rx_byte[0]) begin
                     ack_r <= rd_ok;
                     txsh  <= space_loc ? lreg_data : (sen_hit ? f_data : INVALID_BYTE);
                  end else begin
                     ack_r     <= is_loc | is_sen;
                     space_loc <= is_loc;
                     idx_ok    <= 1'b0;
                  end
               end
            end
            ST_DEV_ACK: if (scl_fall) begin
               if (!in_ack) begin
                  sda_oe <= ack_r;
                  in_ack <= 1'b1;
               end else begin
                  in_ack <= 1'b0;
                  if (!ack_r) begin
                     sda_oe <= 1'b0;
                     st     <= ST_WAIT;
                  end else if (!rd_r) begin
                     sda_oe <= 1'b0;
                     cnt    <= '0;
                     st     <= ST_SUB;
                  end else begin
                     sda_oe <= ~txsh[BYTE_W-1];
                     txsh   <= {txsh[BYTE_W-2:0], 1'b0};
                     cnt    <= 3'd1;
                     st     <= ST_TX;
                  end
               end
            end
            ST_SUB: if (scl_rise) begin
               shreg <= rx_byte[IDX_W-1:0];
               cnt   <= cnt + 3'd1;
               if (sub_done) begin
                  ack_r  <= rx_byte[BYTE_W-1] == space_loc;
                  in_ack <= 1'b0;
                  st     <= ST_SUB_ACK;
                  if (rx_byte[BYTE_W-1] == space_loc) begin
                     idx_q  <= rx_byte[IDX_W-1:0];
                     idx_ok <= 1'b1;
                  end
               end
            end
            ST_SUB_ACK: if (scl_fall) begin
               if (!in_ack) begin
                  sda_oe <= ack_r;
                  in_ack <= 1'b1;
               end else begin
                  sda_oe <= 1'b0;
                  in_ack <= 1'b0;
                  st     <= ST_WAIT;
               end
            end
            ST_TX: if (scl_fall) begin
               if (cnt == 3'd0) begin
                  sda_oe <= 1'b0;
                  st     <= ST_MACK;
               end else begin
                  sda_oe <= ~txsh[BYTE_W-1];
                  txsh   <= {txsh[BYTE_W-2:0], 1'b0};
                  cnt    <= cnt + 3'd1;
               end
            end
            ST_MACK: if (scl_rise) st <= ST_WAIT;
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/sbr_checker.sv
module sbr_checker (
   input logic clk,
   input logic rst_n,
   input logic scl_i,
   input logic sda_oe,
   input logic stop_det,
   input logic fetch_req,
   input logic fetch_vld
);
   logic outstanding;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         outstanding <= 1'b0;
      else if (fetch_req) outstanding <= 1'b1;
      else if (fetch_vld) outstanding <= 1'b0;
   end

   assert_oe_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> !scl_i);

   assert_stop_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> !sda_oe);

   assert_single_outstanding_R11: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_req |-> (!outstanding || fetch_vld));

   assert_req_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_req |=> !fetch_req);
endmodule

bind sreg_bridge_slave sbr_checker u_chk (
   .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
   .stop_det(stop_det), .fetch_req(fetch_req), .fetch_vld(fetch_vld)
);

// File: tb/sreg_bridge_slave_test.sv
`timescale 1ns/1ps
module sreg_bridge_slave_test;
   localparam int Q = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1;
   logic       sda_m = 1'b1;
   logic       sda_bus;
   logic       sda_oe;
   logic [6:0] lreg_addr;
   logic [7:0] lreg_data;
   logic       fetch_req;
   logic [6:0] fetch_addr;
   logic       fetch_vld;
   logic [7:0] fetch_data;

   int n_chk = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   assign sda_bus = sda_m & ~sda_oe;

   function automatic logic [7:0] f_loc(input logic [6:0] a);
      return {~a[3:0], a[6:3]};
   endfunction
   function automatic logic [7:0] f_sen(input logic [6:0] a);
      return {1'b0, a} ^ 8'hA5;
   endfunction

   assign lreg_data = f_loc(lreg_addr);

   sreg_bridge_slave uut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
      .lreg_addr(lreg_addr), .lreg_data(lreg_data),
      .fetch_req(fetch_req), .fetch_addr(fetch_addr),
      .fetch_vld(fetch_vld), .fetch_data(fetch_data)
   );

   // sensor-side model: one request at a time, answer after lat cycles
   int         lat = 5;
   int         cd = 0;
   int         req_cnt = 0;
   int         vld_cnt = 0;
   logic       mbusy = 1'b0;
   logic [6:0] last_req = '0;

   always @(posedge clk) begin
      fetch_vld <= 1'b0;
      if (!rst_n) begin
         mbusy      <= 1'b0;
         fetch_data <= '0;
      end else if (fetch_req) begin
         mbusy    <= 1'b1;
         cd       <= lat;
         last_req <= fetch_addr;
         req_cnt  <= req_cnt + 1;
      end else if (mbusy) begin
         if (cd <= 1) begin
            fetch_vld  <= 1'b1;
            fetch_data <= f_sen(last_req);
            mbusy      <= 1'b0;
            vld_cnt    <= vld_cnt + 1;
         end else begin
            cd <= cd - 1;
         end
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic qwait();
      repeat (Q) @(negedge clk);
   endtask

   task automatic m_start();
      if (!scl_m) begin
         sda_m = 1'b1; qwait();
         scl_m = 1'b1; qwait();
      end
      sda_m = 1'b0; qwait();
      scl_m = 1'b0; qwait();
   endtask

   task automatic m_stop();
      sda_m = 1'b0; qwait();
      scl_m = 1'b1; qwait();
      sda_m = 1'b1; qwait();
   endtask

   task automatic m_wbit(input logic b);
      sda_m = b;    qwait();
      scl_m = 1'b1; qwait(); qwait();
      scl_m = 1'b0; qwait();
   endtask

   task automatic m_rbit(output logic b);
      sda_m = 1'b1; qwait();
      scl_m = 1'b1; qwait();
      b = sda_bus;  qwait();
      scl_m = 1'b0; qwait();
   endtask

   task automatic m_wbyte(input logic [7:0] v, output logic ack);
      logic b;
      for (int i = 7; i >= 0; i--) m_wbit(v[i]);
      m_rbit(b);
      ack = !b;
   endtask

   task automatic m_rbyte(output logic [7:0] v);
      for (int i = 7; i >= 0; i--) m_rbit(v[i]);
      m_wbit(1'b0);
   endtask

   task automatic rd_txn(input logic [6:0] dw, input logic [7:0] sub, input logic [6:0] dr,
                         input bit with_w, output logic aw, output logic as,
                         output logic ar, output logic [7:0] d);
      aw = 1'b1; as = 1'b1; ar = 1'b0; d = '0;
      m_start();
      if (with_w) begin
         m_wbyte({dw, 1'b0}, aw);
         if (aw) m_wbyte(sub, as);
         if (!(aw && as)) begin
            m_stop(); qwait();
            return;
         end
         m_start();
      end
      m_wbyte({dr, 1'b1}, ar);
      if (ar) m_rbyte(d);
      m_stop(); qwait();
   endtask

   task automatic wait_vld(input int n);
      while (vld_cnt < n) @(negedge clk);
      repeat (4) @(negedge clk);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog R1..: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      logic aw, as, ar;
      logic [7:0] d;
      int rq;
      logic [7:0] subs [4];
      subs = '{8'h00, 8'h7F, 8'h33, 8'h4C};

      repeat (5) @(negedge clk);
      chk("R1 sda_oe after reset", 32'(sda_oe), 0);
      chk("R1 fetch_req after reset", 32'(fetch_req), 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      // R2: foreign device addresses
      rd_txn(7'h30, 8'h80, 7'h30, 1, aw, as, ar, d);
      chk("R2 addr 0x30 nack", 32'(aw), 0);
      rd_txn(7'h21, 8'h80, 7'h21, 1, aw, as, ar, d);
      chk("R2 addr 0x21 nack", 32'(aw), 0);
      rd_txn(7'h10, 8'h05, 7'h10, 1, aw, as, ar, d);
      chk("R2 addr 0x10 nack", 32'(aw), 0);

      // R3: index space mismatch
      rd_txn(7'h20, 8'h05, 7'h20, 1, aw, as, ar, d);
      chk("R3 local dev ack", 32'(aw), 1);
      chk("R3 low index under 0x20 nack", 32'(as), 0);
      rd_txn(7'h11, 8'h85, 7'h11, 1, aw, as, ar, d);
      chk("R3 high index under 0x11 nack", 32'(as), 0);
      chk("R10 released after stop", 32'(sda_oe), 0);

      // R4: local sweep
      for (int k = 0; k < 16; k++) begin
         logic [7:0] s;
         s = 8'h80 | 8'((k * 37) % 128);
         rd_txn(7'h20, s, 7'h20, 1, aw, as, ar, d);
         chk("R2 local dev ack", 32'(aw), 1);
         chk("R3 local index ack", 32'(as), 1);
         chk("R4 local read ack", 32'(ar), 1);
         chk("R4 local data", 32'(d), 32'(f_loc(s[6:0])));
      end
      chk("R11 no fetch for local reads", req_cnt, 0);

      // R5/R7: short latency two-read flow
      lat = 5;
      for (int k = 0; k < 4; k++) begin
         rq = req_cnt;
         rd_txn(7'h11, subs[k], 7'h11, 1, aw, as, ar, d);
         chk("R5 first read ack", 32'(ar), 1);
         chk("R5 first read placeholder", 32'(d), 32'hFF);
         chk("R11 one request per first read", req_cnt, rq + 1);
         chk("R5 request index", 32'(last_req), 32'(subs[k][6:0]));
         wait_vld(rq + 1);
         rd_txn(7'h11, subs[k], 7'h11, 1, aw, as, ar, d);
         chk("R7 second read ack", 32'(ar), 1);
         chk("R7 second read data", 32'(d), 32'(f_sen(subs[k][6:0])));
         chk("R7 no request on second read", req_cnt, rq + 1);
         rd_txn(7'h11, subs[k], 7'h11, 1, aw, as, ar, d);
         chk("R7 result consumed", 32'(d), 32'hFF);
         chk("R7 consumed read refetches", req_cnt, rq + 2);
         wait_vld(rq + 2);
      end

      // R6: long latency, second read refused
      lat = 3000;
      rq = req_cnt;
      rd_txn(7'h11, 8'h2A, 7'h11, 1, aw, as, ar, d);
      chk("R5 long first read placeholder", 32'(d), 32'hFF);
      rd_txn(7'h11, 8'h2A, 7'h11, 1, aw, as, ar, d);
      chk("R6 read while pending nack", 32'(ar), 0);
      chk("R6 no extra request", req_cnt, rq + 1);
      chk("R10 released after refused read", 32'(sda_oe), 0);
      wait_vld(rq + 1);
      rd_txn(7'h11, 8'h2A, 7'h11, 1, aw, as, ar, d);
      chk("R7 read after completion ack", 32'(ar), 1);
      chk("R7 read after completion data", 32'(d), 32'(f_sen(7'h2A)));

      // R8: retarget while pending
      rq = req_cnt;
      rd_txn(7'h11, 8'h15, 7'h11, 1, aw, as, ar, d);
      chk("R5 first read of 0x15", 32'(d), 32'hFF);
      rd_txn(7'h11, 8'h61, 7'h11, 1, aw, as, ar, d);
      chk("R8 other index ack", 32'(ar), 1);
      chk("R8 other index placeholder", 32'(d), 32'hFF);
      wait_vld(rq + 2);
      chk("R8 reissued request count", req_cnt, rq + 2);
      chk("R8 reissued request index", 32'(last_req), 32'h61);
      rd_txn(7'h11, 8'h61, 7'h11, 1, aw, as, ar, d);
      chk("R8 new index data", 32'(d), 32'(f_sen(7'h61)));
      lat = 20;
      rq = req_cnt;
      rd_txn(7'h11, 8'h15, 7'h11, 1, aw, as, ar, d);
      chk("R8 old result discarded", 32'(d), 32'hFF);
      chk("R8 old index refetched", req_cnt, rq + 1);
      wait_vld(rq + 1);
      rd_txn(7'h11, 8'h44, 7'h11, 1, aw, as, ar, d);
      chk("R8 stored result replaced", 32'(d), 32'hFF);
      wait_vld(rq + 2);
      rd_txn(7'h11, 8'h15, 7'h11, 1, aw, as, ar, d);
      chk("R8 replaced index no longer stored", 32'(d), 32'hFF);
      wait_vld(rq + 3);

      // R9: space mismatch in read phase, and read with no index
      rd_txn(7'h20, 8'h90, 7'h11, 1, aw, as, ar, d);
      chk("R9 mismatched read space nack", 32'(ar), 0);
      rd_txn(7'h11, 8'h10, 7'h20, 1, aw, as, ar, d);
      chk("R9 mismatched read space nack (sensor)", 32'(ar), 0);
      rd_txn(7'h20, 8'h90, 7'h20, 0, aw, as, ar, d);
      chk("R9 read with no index nack", 32'(ar), 0);
      chk("R10 released at end", 32'(sda_oe), 0);
      chk("R11 no request in idle", 32'(fetch_req), 0);

      summary();
      $finish;
   end
endmodule